// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block holds the 13-bit instruction fetch address of a small Harvard-style microcontroller, together with an eight-entry return-address stack. Each clock the instruction decoder presents at most a few operation strobes: advance to the next word, take an interrupt, call, jump, one of three return kinds, or a computed write to the low byte of the counter. The block picks the winning operation, updates the counter and pushes or pops the stack as needed.

The upper counter bits are never written directly. A five-bit page latch, loaded by its own strobe, supplies them: bits 4:3 become the page on calls and jumps, and all five bits become the high part on a low-byte write. Returns restore the full 13-bit value, so the latch is never adjusted for them. The stack wraps silently in both directions and reports no status. A one-cycle flush flag tells the fetch stage to discard its prefetched word after any change of flow.

Top module: `pc_stack_unit`

## Requirements
- R1: With `step_i` as the only strobe, `pc_o` becomes `pc_o + 1` at the next edge, wrapping from 0x1FFF to 0x0000.
- R2: While `rst_ni` is low, `pc_o` is 0x0000, `latch_o` is 0 and `flush_o` is 0; the stack pointer returns to its first slot.
- R3: `irq_ack_i` pushes the current `pc_o` and loads 0x0004 into the counter; it leaves `latch_o` unchanged.
- R4: `call_i` pushes the current `pc_o` and loads `{latch_o[4:3], imm_i[10:0]}`.
- R5: `goto_i` loads `{latch_o[4:3], imm_i[10:0]}` and does not touch the stack.
- R6: Each of `ret_i`, `retlw_i` and `retfie_i` pops the most recently pushed 13-bit value into the counter (last in, first out).
- R7: The stack has eight slots; a ninth push overwrites the first push, and after nine pushes the ninth pop returns the ninth pushed value again.
- R8: `pcl_wr_i` loads `{latch_o[4:0], pcl_data_i[7:0]}` into the counter in one edge.
- R9: `flush_o` is 1 for exactly the cycle after an interrupt, call, jump, return or low-byte write, and 0 after a step or idle cycle.
- R10: When several strobes are high, priority is interrupt, call, jump, return, low-byte write, step; only the winner acts.
- R11: `latch_wr_i` loads `latch_data_i` into `latch_o` at the edge; a branch in the same cycle uses the old latch value; no other operation changes `latch_o`.
- R12: A pop with nothing pushed returns the slot the wrapped pointer selects (0x0000 straight after reset) and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Advance to next word |
| irq_ack_i | input | 1 | Interrupt accepted, branch to vector |
| call_i | input | 1 | Subroutine call |
| goto_i | input | 1 | Unconditional jump |
| ret_i | input | 1 | Plain return |
| retlw_i | input | 1 | Return with literal |
| retfie_i | input | 1 | Return from interrupt |
| pcl_wr_i | input | 1 | Computed write of low byte |
| pcl_data_i | input | 8 | Low-byte write data |
| imm_i | input | 11 | In-page branch target |
| latch_wr_i | input | 1 | Page latch write strobe |
| latch_data_i | input | 5 | Page latch write data |
| pc_o | output | 13 | Fetch address |
| latch_o | output | 5 | Page latch value |
| flush_o | output | 1 | Discard prefetched word |

## Verification
The hardest state to reach is the wrapped stack: the ninth push must overwrite the oldest slot and later pops must cycle through stale entries, which random traffic seldom produces because returns and calls roughly balance. A directed run issues nine calls with distinct targets followed by nine returns, and a pop straight after reset covers the empty case. Random mixes of all strobes, including simultaneous ones and latch writes coinciding with branches, then run against a bench model of the counter, latch and stack.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    PC_HOLD,
    PC_STEP,
    PC_VEC,
    PC_BRANCH,
    PC_POP,
    PC_LOW
  } pc_sel_e;
endpackage

// File: rtl/pcu_op_arbiter.sv
module pcu_op_arbiter
  import pcu_pkg::*;
(
  input  logic    step_i,
  input  logic    irq_ack_i,
  input  logic    call_i,
  input  logic    goto_i,
  input  logic    ret_any_i,
  input  logic    pcl_wr_i,
  output pc_sel_e sel_o,
  output logic    push_o,
  output logic    pop_o,
  output logic    flush_req_o
);
  always_comb begin
    sel_o  = PC_HOLD;
    push_o = 1'b0;
    pop_o  = 1'b0;
    if (irq_ack_i) begin
      sel_o  = PC_VEC;
      push_o = 1'b1;
    end else if (call_i) begin
      sel_o  = PC_BRANCH;
      push_o = 1'b1;
    end else if (goto_i) begin
      sel_o = PC_BRANCH;
    end else if (ret_any_i) begin
      sel_o = PC_POP;
      pop_o = 1'b1;
    end else if (pcl_wr_i) begin
      sel_o = PC_LOW;
    end else if (step_i) begin
      sel_o = PC_STEP;
    end
  end

  assign flush_req_o = (sel_o != PC_HOLD) && (sel_o != PC_STEP);
endmodule

// File: rtl/pcu_return_stack.sv
module pcu_return_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_inc, ptr_dec;

  // pointer wraps both ways; no status kept
  assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
  assign ptr_dec = (ptr_q == '0) ? LAST : ptr_q - PTR_W'(1);
  assign top_o   = mem_q[ptr_dec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (push_i) begin
      ptr_q <= ptr_inc;
    end else if (pop_i) begin
      ptr_q <= ptr_dec;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (push_i && (ptr_q == PTR_W'(g))) begin
        mem_q[g] <= push_data_i;
      end
    end
  end

  p_push_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (top_o == $past(push_data_i)));

  p_no_dual_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] latch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_o <= '0;
    else if (wr_i) latch_o <= data_i;
  end

  p_latch_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(latch_o));
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcu_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int IMM_W     = 11,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter int RESET_VEC = 0,
  parameter int IRQ_VEC   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic                     irq_ack_i,
  input  logic                     call_i,
  input  logic                     goto_i,
  input  logic                     ret_i,
  input  logic                     retlw_i,
  input  logic                     retfie_i,
  input  logic                     pcl_wr_i,
  input  logic [DATA_W-1:0]        pcl_data_i,
  input  logic [IMM_W-1:0]         imm_i,
  input  logic                     latch_wr_i,
  input  logic [PC_W-DATA_W-1:0]   latch_data_i,
  output logic [PC_W-1:0]          pc_o,
  output logic [PC_W-DATA_W-1:0]   latch_o,
  output logic                     flush_o
);
  localparam int HI_W     = PC_W - DATA_W;
  localparam int PAGE_W   = PC_W - IMM_W;
  localparam int PAGE_LSB = IMM_W - DATA_W;

  pc_sel_e          sel;
  logic             push, pop, flush_req, ret_any;
  logic [PC_W-1:0]  pc_q, pc_d, stack_top;
  logic [HI_W-1:0]  latch_q;

  assign ret_any = ret_i | retlw_i | retfie_i;

  pcu_op_arbiter u_arb (
    .step_i      (step_i),
    .irq_ack_i   (irq_ack_i),
    .call_i      (call_i),
    .goto_i      (goto_i),
    .ret_any_i   (ret_any),
    .pcl_wr_i    (pcl_wr_i),
    .sel_o       (sel),
    .push_o      (push),
    .pop_o       (pop),
    .flush_req_o (flush_req)
  );

  pcu_return_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (pc_q),
    .top_o       (stack_top)
  );

  pcu_page_latch #(.W(HI_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (latch_wr_i),
    .data_i  (latch_data_i),
    .latch_o (latch_q)
  );

  always_comb begin
    unique case (sel)
      PC_STEP:   pc_d = pc_q + PC_W'(1);
      PC_VEC:    pc_d = PC_W'(IRQ_VEC);
      PC_BRANCH: pc_d = {latch_q[PAGE_LSB +: PAGE_W], imm_i};
      PC_POP:    pc_d = stack_top;
      PC_LOW:    pc_d = {latch_q, pcl_data_i};
      default:   pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= PC_W'(RESET_VEC);
      flush_o <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      flush_o <= flush_req;
    end
  end

  assign pc_o    = pc_q;
  assign latch_o = latch_q;

  logic any_flow;
  assign any_flow = irq_ack_i | call_i | goto_i | ret_any | pcl_wr_i;

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !any_flow) |=> (pc_o == $past(pc_o) + PC_W'(1)));

  p_irq_vec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> (pc_o == PC_W'(IRQ_VEC)));

  p_jump_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (goto_i && !irq_ack_i && !call_i) |=>
      (pc_o == {$past(latch_o[PAGE_LSB +: PAGE_W]), $past(imm_i)}));

  p_low_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcl_wr_i && !irq_ack_i && !call_i && !goto_i && !ret_any) |=>
      (pc_o == {$past(latch_o), $past(pcl_data_i)}));

  p_flush_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_flow |=> flush_o);

  p_flush_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_flow |=> !flush_o);
endmodule

// File: tb/tb_pc_stack_unit.sv
module tb_pc_stack_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 0, irq_ack_i = 0, call_i = 0, goto_i = 0;
  logic        ret_i = 0, retlw_i = 0, retfie_i = 0, pcl_wr_i = 0, latch_wr_i = 0;
  logic [7:0]  pcl_data_i = '0;
  logic [10:0] imm_i = '0;
  logic [4:0]  latch_data_i = '0;
  logic [12:0] pc_o;
  logic [4:0]  latch_o;
  logic        flush_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [12:0] m_pc;
  logic [12:0] m_stk [8];
  int          m_ptr;
  logic [4:0]  m_lat;
  logic        m_fl;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_stack_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .irq_ack_i(irq_ack_i),
    .call_i(call_i), .goto_i(goto_i), .ret_i(ret_i), .retlw_i(retlw_i),
    .retfie_i(retfie_i), .pcl_wr_i(pcl_wr_i), .pcl_data_i(pcl_data_i),
    .imm_i(imm_i), .latch_wr_i(latch_wr_i), .latch_data_i(latch_data_i),
    .pc_o(pc_o), .latch_o(latch_o), .flush_o(flush_o)
  );

  function automatic logic [12:0] branch_target(logic [4:0] lat, logic [10:0] imm);
    return {lat[4:3], imm};
  endfunction

  task automatic model_reset();
    m_pc = '0; m_ptr = 0; m_lat = '0; m_fl = 1'b0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
  endtask

  task automatic check(string tag);
    checks++;
    if (pc_o !== m_pc || latch_o !== m_lat || flush_o !== m_fl) begin
      errors++;
      $display("FAIL %s pc=%h lat=%h fl=%b expected pc=%h lat=%h fl=%b",
               tag, pc_o, latch_o, flush_o, m_pc, m_lat, m_fl);
    end
  endtask

  // drive one cycle at negedge, update model, check at next negedge
  task automatic cycle(input logic irq, call, gt, r0, r1, r2, pw, st, lw,
                       input logic [10:0] imm, input logic [7:0] d,
                       input logic [4:0] ld, input string tag);
    logic [12:0] nxt;
    logic chg;
    irq_ack_i = irq; call_i = call; goto_i = gt; ret_i = r0; retlw_i = r1;
    retfie_i = r2; pcl_wr_i = pw; step_i = st; latch_wr_i = lw;
    imm_i = imm; pcl_data_i = d; latch_data_i = ld;
    nxt = m_pc; chg = 1'b1;
    if (irq) begin
      m_stk[m_ptr] = m_pc; m_ptr = (m_ptr + 1) % 8; nxt = 13'h0004;
    end else if (call) begin
      m_stk[m_ptr] = m_pc; m_ptr = (m_ptr + 1) % 8; nxt = branch_target(m_lat, imm);
    end else if (gt) begin
      nxt = branch_target(m_lat, imm);
    end else if (r0 || r1 || r2) begin
      m_ptr = (m_ptr + 7) % 8; nxt = m_stk[m_ptr];
    end else if (pw) begin
      nxt = {m_lat, d};
    end else begin
      chg = 1'b0;
      if (st) nxt = m_pc + 13'd1;
    end
    if (lw) m_lat = ld;
    m_pc = nxt; m_fl = chg;
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    {step_i, irq_ack_i, call_i, goto_i, ret_i, retlw_i, retfie_i, pcl_wr_i, latch_wr_i} = '0;
    model_reset();
    @(negedge clk);
    check("R2 reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R2 after release");
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    @(negedge clk);
    do_reset();

    // R12: pop with nothing pushed
    cycle(0,0,0,1,0,0,0,0,0, '0, '0, '0, "R12 empty pop");
    cycle(0,0,0,0,0,0,0,0,0, '0, '0, '0, "R9 idle clears flush");

    // R1: counter wrap via low-byte write with full latch
    cycle(0,0,0,0,0,0,0,0,1, '0, '0, 5'h1F, "R11 latch write");
    cycle(0,0,0,0,0,0,1,0,0, '0, 8'hFF, '0, "R8 low write");
    cycle(0,0,0,0,0,0,0,1,0, '0, '0, '0, "R1 wrap to zero");
    cycle(0,0,0,0,0,0,0,1,0, '0, '0, '0, "R1 step");

    // R11: branch uses old latch while latch is rewritten
    cycle(0,0,1,0,0,0,0,0,1, 11'h123, '0, 5'h08, "R11 goto old latch");
    cycle(0,0,1,0,0,0,0,0,0, 11'h456, '0, '0, "R5 goto new page");

    // R10: all strobes at once, interrupt wins
    cycle(1,1,1,1,1,1,1,1,0, 11'h7FF, 8'hAA, '0, "R10 priority irq");
    cycle(0,1,1,1,0,0,1,1,0, 11'h0F0, 8'h55, '0, "R10 call over goto");
    cycle(0,0,0,0,0,1,0,0,0, '0, '0, '0, "R6 retfie");
    cycle(0,0,0,0,1,0,0,0,0, '0, '0, '0, "R3 irq return addr");

    // R7: nine calls then nine returns
    do_reset();
    cycle(0,0,0,0,0,0,0,0,1, '0, '0, 5'h10, "R11 latch write");
    for (int i = 0; i < 9; i++)
      cycle(0,1,0,0,0,0,0,0,0, 11'(16 * (i + 1)), '0, '0, "R7 push");
    for (int i = 0; i < 9; i++)
      cycle(0,0,0,1,0,0,0,0,0, '0, '0, '0, "R7 pop wrap");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [8:0] s;
      string tag;
      k = $urandom_range(0, 99);
      s = '0;
      if (k < 35)      begin s[7] = 1; tag = "R1 rand step"; end
      else if (k < 45) begin s[1] = 1; tag = "R4 rand call"; end
      else if (k < 53) begin s[2] = 1; tag = "R5 rand goto"; end
      else if (k < 58) begin s[3] = 1; tag = "R6 rand ret"; end
      else if (k < 63) begin s[4] = 1; tag = "R6 rand retlw"; end
      else if (k < 67) begin s[5] = 1; tag = "R6 rand retfie"; end
      else if (k < 73) begin s[0] = 1; tag = "R3 rand irq"; end
      else if (k < 79) begin s[6] = 1; tag = "R8 rand low write"; end
      else if (k < 85) begin s = 9'($urandom()); tag = "R10 rand mixed"; end
      else             begin tag = "R9 rand idle"; end
      if ($urandom_range(0, 5) == 0) s[8] = 1'b1;
      cycle(s[0], s[1], s[2], s[3], s[4], s[5], s[6], s[7], s[8],
            11'($urandom()), 8'($urandom()), 5'($urandom()), tag);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule